// File: doc/BRIEF.md
# Linked-Pair Output-Compare PWM Timer

This block is a small timer built around a free-running up-counter that returns to zero after reaching a programmable modulo value. Two output-compare channels watch the counter. Each channel drives one pin, which toggles when the counter overflows and is forced to a fixed level when the counter equals the channel's compare value. The duty cycle is set by the compare value. Explicit controls give a guaranteed 0% output (overflow toggling disabled) and a guaranteed 100% output (maximum-duty override).

Channel 0 can be linked with channel 1 into a single buffered PWM output. In that mode the two compare registers act as a double buffer. Software writes a new width into the register that is not in use, and the hardware switches to it at the next overflow. This means a width change never lands in the middle of a period.

Flags for overflow and for each channel's compare event are write-one-to-clear. Each flag raises an interrupt request only when its enable bit is set. All configuration goes through a simple single-cycle register write port.

Top module: `pwm_pair_timer`

## Requirements
- R1: Register write port. A write happens on the rising clock edge where wrEn is high, using the offset on wrAddr.
  - Offset 0 is timer control: bit0 stop (1 halts the counter), bit1 overflow interrupt enable, bit2 overflow flag (write 1 clears).
  - Offset 1 is the modulo value.
  - Offsets 2 and 3 are the control registers of channels 0 and 1: bits1:0 mode {high,low}, bits3:2 compare action {high,low}, bit4 toggle-on-overflow, bit5 maximum duty, bit6 interrupt enable, bit7 flag (write 1 clears).
  - Offsets 4 and 5 are the compare values of channels 0 and 1.
- R2: After reset the counter is stopped at zero, the modulo value is all ones, every other register is zero, both pins are low and no interrupt request is raised.
- R3: The counter advances by one per clock only while stop is 0. It returns to zero on the clock after it equals the modulo value, so one period lasts modulo+1 cycles. While stopped it holds its value.
- R4: The overflow flag is set on the clock after a running counter equals the modulo value. ovfIrq is the flag ANDed with its enable. Writing 1 to the flag clears it, but a set in the same cycle wins over the clear.
- R5: A channel in an enabled, unlinked mode matches when the counter is running and equals its compare value. On a match, compare action 10 drives the pin low, 11 drives it high, 01 toggles it and 00 leaves it unchanged. When toggle-on-overflow is 1, an overflow toggles the pin. With action 10 and compare value C below modulo M, the pin is high C+1 cycles per period. With action 11 it is high M-C cycles per period.
- R6: If a match and an overflow occur in the same cycle, the match action decides the pin. A compare value equal to the modulo therefore gives 0% duty with action 10.
- R7: With toggle-on-overflow 0 and action 10, the pin settles low and stays low (0% duty).
- R8: With maximum duty and toggle-on-overflow both 1, the pin is held at the pulse level every cycle: high for action 10, low for action 11.
- R9: A channel's flag is set on the clock after its match. chIrq for that channel is the flag ANDed with the channel's interrupt enable. Writing 1 to the flag clears it, but a set in the same cycle wins.
- R10: Channel 0 mode 10 or 11 links the pair, so the high mode bit takes priority over the low bit. While linked, channel 0's control settings and flag govern the shared output on pwmOut[0], pwmOut[1] is low and channel 1's flag is never set.
- R11: When the pair becomes linked, channel 0's compare value is in use. A write to the compare register not in use takes effect at the next overflow, and from then on that register is in use.
- R12: A channel in mode 00 holds its pin low and never sets its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register offset |
| wrData | input | CNT_W | Write data |
| pwmOut | output | 2 | Channel pin levels, index = channel |
| ovfIrq | output | 1 | Overflow interrupt request |
| chIrq | output | 2 | Channel interrupt requests, index = channel |

## Verification
The bench builds the timer with CNT_W = 8. With that width the reset modulo of 255 is short enough that a full stopped-counter window can be observed. The bench then programs a modulo of 9, so a ten-cycle period lets each duty pattern be measured over whole periods in a few dozen cycles. The short period also makes the overflow edge cycle-predictable from the moment the counter starts. That is how a flag clear can be landed exactly on the same edge as a flag set.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

  localparam int NUM_CH = 2;

  localparam logic [2:0] ADDR_TCTRL = 3'd0;
  localparam logic [2:0] ADDR_MOD   = 3'd1;
  localparam logic [2:0] ADDR_CTL0  = 3'd2;
  localparam logic [2:0] ADDR_CMP0  = 3'd4;

  localparam int TC_STOP = 0;
  localparam int TC_OIE  = 1;
  localparam int TC_OF   = 2;

  localparam int CC_MODE_LO = 0;
  localparam int CC_MODE_HI = 1;
  localparam int CC_ACT_LO  = 2;
  localparam int CC_ACT_HI  = 3;
  localparam int CC_TOV     = 4;
  localparam int CC_MAX     = 5;
  localparam int CC_IE      = 6;
  localparam int CC_FLAG    = 7;

  typedef struct packed {
    logic              run;
    logic [NUM_CH-1:0] chEn;
    logic [NUM_CH-1:0] actHi;
    logic [NUM_CH-1:0] actLo;
    logic [NUM_CH-1:0] tovEn;
    logic [NUM_CH-1:0] forceMax;
  } dpStrobe_t;

  typedef struct packed {
    logic              ovf;
    logic [NUM_CH-1:0] match;
  } dpEvent_t;

endpackage

// File: rtl/pwm_pair_dp.sv
module pwm_pair_dp
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     strb,
  input  logic [CNT_W-1:0]              modVal,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cmpEff,
  output dpEvent_t                      evt,
  output logic [NUM_CH-1:0]             pinOut
);

  logic [CNT_W-1:0] cnt;
  logic             atMod;

  assign atMod = (cnt == modVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.run) begin
      cnt <= atMod ? '0 : cnt + 1'b1;
    end
  end

  always_comb begin
    evt.ovf = strb.run && atMod;
    for (int i = 0; i < NUM_CH; i++) begin
      evt.match[i] = strb.run && strb.chEn[i] && (cnt == cmpEff[i]);
    end
  end

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> $stable(cnt)); // R3

  for (genvar g = 0; g < NUM_CH; g++) begin : gPin
    logic pin;
    logic zeroCfg;
    logic fullCfg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pin <= 1'b0;
      end else if (!strb.chEn[g]) begin
        pin <= 1'b0;
      end else if (strb.forceMax[g] && strb.tovEn[g]) begin
        pin <= ~strb.actLo[g];
      end else if (evt.match[g]) begin
        case ({strb.actHi[g], strb.actLo[g]})
          2'b01:   pin <= ~pin;
          2'b10:   pin <= 1'b0;
          2'b11:   pin <= 1'b1;
          default: pin <= pin;
        endcase
      end else if (evt.ovf && strb.tovEn[g]) begin
        pin <= ~pin;
      end
    end

    assign pinOut[g] = pin;

    assign zeroCfg = strb.chEn[g] && !strb.tovEn[g] && !strb.forceMax[g]
                     && strb.actHi[g] && !strb.actLo[g];
    assign fullCfg = strb.chEn[g] && strb.tovEn[g] && strb.forceMax[g];

    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rstN)
      (zeroCfg && $past(zeroCfg) && !$past(pin)) |-> !pin); // R7

    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rstN)
      (fullCfg && $past(fullCfg) && $stable(strb.actLo[g]))
        |-> (pin == !strb.actLo[g])); // R8
  end

endmodule

// File: rtl/pwm_pair_ctrl.sv
module pwm_pair_ctrl
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [2:0]                    wrAddr,
  input  logic [CNT_W-1:0]              wrData,
  input  dpEvent_t                      evt,
  output dpStrobe_t                     strb,
  output logic [CNT_W-1:0]              modVal,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cmpEff,
  output logic                          ovfIrq,
  output logic [NUM_CH-1:0]             chIrq
);

  logic stopBit, ovfIe, ovfFlag;
  logic tcWr, modWr;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpReg;
  logic [NUM_CH-1:0][1:0] chMode, chAct;
  logic [NUM_CH-1:0] chTov, chMax, chIe, chFlag, ctlWr, cmpWr;
  logic activeSel, swapPend, linked, inactiveWr;

  assign tcWr  = wrEn && (wrAddr == ADDR_TCTRL);
  assign modWr = wrEn && (wrAddr == ADDR_MOD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopBit <= 1'b1;
      ovfIe   <= 1'b0;
      ovfFlag <= 1'b0;
      modVal  <= '1;
    end else begin
      if (tcWr) begin
        stopBit <= wrData[TC_STOP];
        ovfIe   <= wrData[TC_OIE];
      end
      if (modWr) modVal <= wrData;
      ovfFlag <= evt.ovf | (ovfFlag & ~(tcWr & wrData[TC_OF]));
    end
  end

  AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    evt.ovf |=> ovfFlag); // R4

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    assign ctlWr[g] = wrEn && (wrAddr == (ADDR_CTL0 + 3'(g)));
    assign cmpWr[g] = wrEn && (wrAddr == (ADDR_CMP0 + 3'(g)));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chMode[g] <= 2'b00;
        chAct[g]  <= 2'b00;
        chTov[g]  <= 1'b0;
        chMax[g]  <= 1'b0;
        chIe[g]   <= 1'b0;
        chFlag[g] <= 1'b0;
        cmpReg[g] <= '0;
      end else begin
        if (ctlWr[g]) begin
          chMode[g] <= {wrData[CC_MODE_HI], wrData[CC_MODE_LO]};
          chAct[g]  <= {wrData[CC_ACT_HI], wrData[CC_ACT_LO]};
          chTov[g]  <= wrData[CC_TOV];
          chMax[g]  <= wrData[CC_MAX];
          chIe[g]   <= wrData[CC_IE];
        end
        if (cmpWr[g]) cmpReg[g] <= wrData;
        chFlag[g] <= evt.match[g] | (chFlag[g] & ~(ctlWr[g] & wrData[CC_FLAG]));
      end
    end

    assign chIrq[g] = chFlag[g] & chIe[g];

    AST_CH_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
      evt.match[g] |=> chFlag[g]); // R9
  end

  // Channel 0's high mode bit decides linking regardless of the low bit.
  assign linked     = chMode[0][1];
  assign inactiveWr = activeSel ? cmpWr[0] : cmpWr[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeSel <= 1'b0;
      swapPend  <= 1'b0;
    end else if (!linked) begin
      activeSel <= 1'b0;
      swapPend  <= 1'b0;
    end else if (evt.ovf && swapPend) begin
      activeSel <= ~activeSel;
      swapPend  <= 1'b0;
    end else if (inactiveWr) begin
      swapPend  <= 1'b1;
    end
  end

  AST_SWAP_AT_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (linked && $past(linked) && (activeSel != $past(activeSel)))
      |-> $past(evt.ovf)); // R11

  AST_ODD_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (linked && $past(linked) && !$past(chFlag[1])) |-> !chFlag[1]); // R10

  always_comb begin
    strb.run      = !stopBit;
    strb.chEn[0]  = |chMode[0];
    strb.chEn[1]  = (|chMode[1]) && !linked;
    strb.actHi    = {chAct[1][1], chAct[0][1]};
    strb.actLo    = {chAct[1][0], chAct[0][0]};
    strb.tovEn    = chTov;
    strb.forceMax = chMax;
    cmpEff[0]     = (linked && activeSel) ? cmpReg[1] : cmpReg[0];
    cmpEff[1]     = cmpReg[1];
  end

  assign ovfIrq = ovfFlag & ovfIe;

endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic [1:0]       pwmOut,
  output logic             ovfIrq,
  output logic [1:0]       chIrq
);

  dpStrobe_t                    strb;
  dpEvent_t                     evt;
  logic [CNT_W-1:0]             modVal;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpEff;

  pwm_pair_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .evt    (evt),
    .strb   (strb),
    .modVal (modVal),
    .cmpEff (cmpEff),
    .ovfIrq (ovfIrq),
    .chIrq  (chIrq)
  );

  pwm_pair_dp #(.CNT_W(CNT_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .modVal (modVal),
    .cmpEff (cmpEff),
    .evt    (evt),
    .pinOut (pwmOut)
  );

endmodule

// File: tb/pwm_pair_timer_test.sv
`timescale 1ns/1ps
module pwm_pair_timer_test;

  localparam int CNT_W = 8;
  localparam int MODV  = 9;
  localparam int PER   = MODV + 1;
  localparam int NVEC  = 9;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [2:0]       wrAddr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic [1:0]       pwmOut;
  logic             ovfIrq;
  logic [1:0]       chIrq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pwm_pair_timer #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .ovfIrq(ovfIrq), .chIrq(chIrq)
  );

  // {requirement, compare, channel-0 control byte, expected high cycles in 4 periods}
  // control byte: bit0 mode low, bits3:2 action, bit4 toggle-on-overflow, bit5 max duty
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd5, 8'd3, 8'h19, 8'd16},  // R5 clear on compare, C+1 high
    {8'd5, 8'd6, 8'h19, 8'd28},  // R5 wider pulse
    {8'd5, 8'd3, 8'h1D, 8'd24},  // R5 set on compare, M-C high
    {8'd5, 8'd0, 8'h19, 8'd4},   // R5 smallest compare
    {8'd6, 8'd9, 8'h19, 8'd0},   // R6 compare at modulo beats overflow toggle
    {8'd7, 8'd5, 8'h09, 8'd0},   // R7 toggle-on-overflow off
    {8'd8, 8'd5, 8'h39, 8'd40},  // R8 max duty, pulse high
    {8'd8, 8'd5, 8'h3D, 8'd0},   // R8 max duty, pulse low
    {8'd5, 8'd5, 8'h05, 8'd20}   // R5 toggle on compare
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic measure(input int n, output int h0, output int h1);
    h0 = 0; h1 = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      h0 += int'(pwmOut[0]);
      h1 += int'(pwmOut[1]);
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int h0, h1, odd;
    odd = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 pins after reset", int'(pwmOut), 0);
    chk("R2 ovfIrq after reset", int'(ovfIrq), 0);
    chk("R2 chIrq after reset", int'(chIrq), 0);

    // R3: stopped with enable on, reset modulo 255 never reached
    wr(3'd0, 8'h03);
    repeat (300) @(negedge clk);
    chk("R3 no overflow while stopped", int'(ovfIrq), 0);

    // R4: clear lands on the same edge as the set
    wr(3'd1, MODV);
    wr(3'd0, 8'h02);
    chk("R4 flag clear at start", int'(ovfIrq), 0);
    repeat (MODV - 1) @(negedge clk);
    wr(3'd0, 8'h06);
    chk("R4 set wins over clear", int'(ovfIrq), 1);
    wr(3'd0, 8'h03);
    wr(3'd0, 8'h07);
    chk("R4 write-one clears flag", int'(ovfIrq), 0);
    wr(3'd0, 8'h02);
    repeat (PER + 2) @(negedge clk);
    chk("R4 flag raised after period", int'(ovfIrq), 1);
    wr(3'd0, 8'h00);
    chk("R4 enable gates request", int'(ovfIrq), 0);

    for (int v = 0; v < NVEC; v++) begin
      wr(3'd4, VEC[v][23:16]);
      wr(3'd2, VEC[v][15:8]);
      repeat (2 * PER) @(negedge clk);
      measure(4 * PER, h0, h1);
      chk($sformatf("R%0d table row %0d", VEC[v][31:24], v), h0, int'(VEC[v][7:0]));
      odd += h1;
    end
    chk("R12 idle channel 1 stays low", odd, 0);

    // R9: channel flag and request
    wr(3'd2, 8'h59);
    repeat (PER + 2) @(negedge clk);
    chk("R9 channel 0 request", int'(chIrq[0]), 1);
    chk("R12 idle channel 1 no request", int'(chIrq[1]), 0);
    wr(3'd0, 8'h01);
    wr(3'd2, 8'hD9);
    chk("R9 channel 0 flag cleared", int'(chIrq[0]), 0);
    wr(3'd2, 8'h19);
    wr(3'd0, 8'h00);

    // R5: both channels unlinked and independent
    wr(3'd5, 8'd4);
    wr(3'd3, 8'h19);
    repeat (2 * PER) @(negedge clk);
    measure(4 * PER, h0, h1);
    chk("R5 channel 0 width 5", h0, 24);
    chk("R5 channel 1 width 4", h1, 20);

    // R10/R11: link with mode 11, then double-buffered width changes
    wr(3'd4, 8'd2);
    wr(3'd5, 8'd6);
    wr(3'd2, 8'h1B);
    repeat (2 * PER) @(negedge clk);
    measure(4 * PER, h0, h1);
    chk("R11 linked uses channel 0 compare", h0, 12);
    chk("R10 linked odd pin low", h1, 0);
    wr(3'd5, 8'd6);
    repeat (2 * PER) @(negedge clk);
    measure(4 * PER, h0, h1);
    chk("R11 switch to channel 1 compare", h0, 28);
    wr(3'd4, 8'd4);
    repeat (2 * PER) @(negedge clk);
    measure(4 * PER, h0, h1);
    chk("R11 switch back to channel 0 compare", h0, 20);
    chk("R10 odd pin still low", h1, 0);

    // R1: modulo register changes the period
    wr(3'd1, 8'd4);
    wr(3'd4, 8'd1);
    wr(3'd2, 8'h19);
    repeat (10) @(negedge clk);
    measure(20, h0, h1);
    chk("R1 modulo 4 period", h0, 8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule